// File: doc/BRIEF.md
# Dual-Reload Carrier Wave Generator

This block makes a square-wave carrier, as used by infrared remote transmitters, from an 8-bit down counter. Two reload registers set the time the carrier spends low and the time it spends high, so that both the frequency and the duty cycle can be programmed. When the count reaches zero in one phase, the counter reloads from the register of the other phase and the output changes level.

Software-style strobed writes set the reload values and a three-bit control word. The control word starts and stops counting, picks one of two prescaled count sources and can stretch the high phase by one source period. A separate carrier flag gates the output pin. Each reload sets a sticky underflow flag that stays set until a clear strobe. The running count can be read back at any time as two nibbles.

Top module: `carrier_timer`

## Requirements
- R1: After reset the count reads 8'hFF (both nibbles 4'hF), the underflow flag is 0, the carrier output is 0 and counting is stopped.
- R2: A low-load strobe writes the byte {ld_nib_hi, ld_nib_lo} into the low-phase reload register and into the counter in the same clock, and it puts the generator in the low phase. The new value reads back on the next cycle.
- R3: While running, the count drops by exactly one on each count-source tick.
- R4: Control bit 2 selects the count source. At 0 a tick comes every 2 clocks, and at 1 a tick comes every 8 clocks. A control write restarts the prescaler, so with the fast source the first decrement falls on the second clock after the write and with the slow source on the eighth.
- R5: With reload values L and H and the stretch bit clear, the output is low for (L+1) ticks and high for (H+1) ticks, and the two phases alternate. On each underflow the counter reloads from the register of the opposite phase.
- R6: With control bit 1 set, each high phase lasts (H+2) ticks. The low phase is unchanged.
- R7: Every reload at underflow sets the underflow flag. The flag stays set, even with counting stopped, until a clear strobe, and a clear strobe drops it on the next cycle.
- R8: The carrier flag is set by a set strobe and cleared by a clear strobe (the clear wins if both arrive together). While the flag is clear, the output stays 0.
- R9: With control bit 0 clear, the count holds its value and the output stays 0.
- R10: A high-load strobe writes only the high-phase reload register. The count and the phase are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_nib_lo | input | 4 | Low nibble of the load byte |
| ld_nib_hi | input | 4 | High nibble of the load byte |
| ld_low_stb | input | 1 | Write low-phase reload register and counter |
| ld_high_stb | input | 1 | Write high-phase reload register |
| ctrl_wr_stb | input | 1 | Write control word |
| ctrl_wdata | input | 3 | Control: bit0 run, bit1 stretch high, bit2 slow source |
| car_set_stb | input | 1 | Set carrier gate flag |
| car_clr_stb | input | 1 | Clear carrier gate flag |
| uf_clr_stb | input | 1 | Clear underflow flag |
| uf_flag | output | 1 | Sticky underflow flag |
| rd_nib_lo | output | 4 | Low nibble of current count |
| rd_nib_hi | output | 4 | High nibble of current count |
| carr_out | output | 1 | Carrier output |

## Verification
An error in the count or in the prescaler state appears on the read-back nibbles within one or two source ticks, and it also shows up as a wrong high or low period on the carrier output. A phase bit that never toggles, or that reloads from the wrong register, makes the output intervals swap or freeze within one full carrier period. The bench measures both intervals at the clock level over repeated periods for several reload pairs, for both sources and with and without stretch. A sticky-flag or gating error is visible directly on uf_flag or carr_out in the cycle after the strobe.

// File: rtl/carrier_pkg.sv
package carrier_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // bit0 run, bit1 stretch high phase, bit2 slow count source
    typedef struct packed {
        logic src_slow;
        logic stretch;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/carrier_prescaler.sv
module carrier_prescaler #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic slow_sel,
    output logic tick
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int DIV_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          s_d, s_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = slow_sel ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
        tick  = (s_q.cnt >= limit);
        s_d   = s_q;
        if (restart || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/carrier_regs.sv
module carrier_regs
    import carrier_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ld_low_stb,
    input  logic             ld_high_stb,
    input  logic             ctrl_wr_stb,
    input  logic [2:0]       ctrl_wdata,
    input  logic             car_set_stb,
    input  logic             car_clr_stb,
    output logic [CNT_W-1:0] low_rel,
    output logic [CNT_W-1:0] high_rel,
    output ctrl_t            ctrl,
    output logic             car_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] low_rel;
        logic [CNT_W-1:0] high_rel;
        ctrl_t            ctrl;
        logic             car;
    } reg_st_t;

    reg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld_low_stb)  s_d.low_rel  = ld_val;
        if (ld_high_stb) s_d.high_rel = ld_val;
        if (ctrl_wr_stb) s_d.ctrl     = ctrl_t'(ctrl_wdata);
        if (car_set_stb) s_d.car      = 1'b1;
        if (car_clr_stb) s_d.car      = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.low_rel  <= '1;
            s_q.high_rel <= '1;
            s_q.ctrl     <= '0;
            s_q.car      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign low_rel  = s_q.low_rel;
    assign high_rel = s_q.high_rel;
    assign ctrl     = s_q.ctrl;
    assign car_flag = s_q.car;

endmodule

// File: rtl/carrier_counter.sv
module carrier_counter
    import carrier_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             run,
    input  logic             stretch_en,
    input  logic [CNT_W-1:0] low_rel,
    input  logic [CNT_W-1:0] high_rel,
    input  logic             uf_clr,
    output logic [CNT_W-1:0] count,
    output logic             phase_high,
    output logic             uf_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        phase_e           phase;
        logic             stretched;
        logic             uf;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (uf_clr) s_d.uf = 1'b0;
        if (load_stb) begin
            s_d.count     = load_val;
            s_d.phase     = PH_LOW;
            s_d.stretched = 1'b0;
        end else if (run && tick) begin
            if (s_q.count != '0) begin
                s_d.count = s_q.count - 1'b1;
            end else if (s_q.phase == PH_HIGH && stretch_en && !s_q.stretched) begin
                // hold at zero for one extra source period
                s_d.stretched = 1'b1;
            end else begin
                s_d.uf        = 1'b1;
                s_d.stretched = 1'b0;
                if (s_q.phase == PH_LOW) begin
                    s_d.count = high_rel;
                    s_d.phase = PH_HIGH;
                end else begin
                    s_d.count = low_rel;
                    s_d.phase = PH_LOW;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count     <= '1;
            s_q.phase     <= PH_LOW;
            s_q.stretched <= 1'b0;
            s_q.uf        <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count      = s_q.count;
    assign phase_high = (s_q.phase == PH_HIGH);
    assign uf_flag    = s_q.uf;

endmodule

// File: rtl/carrier_timer.sv
module carrier_timer
    import carrier_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W/2-1:0] ld_nib_lo,
    input  logic [CNT_W/2-1:0] ld_nib_hi,
    input  logic               ld_low_stb,
    input  logic               ld_high_stb,
    input  logic               ctrl_wr_stb,
    input  logic [2:0]         ctrl_wdata,
    input  logic               car_set_stb,
    input  logic               car_clr_stb,
    input  logic               uf_clr_stb,
    output logic               uf_flag,
    output logic [CNT_W/2-1:0] rd_nib_lo,
    output logic [CNT_W/2-1:0] rd_nib_hi,
    output logic               carr_out
);
    localparam int NIB_W = CNT_W / 2;

    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] low_rel;
    logic [CNT_W-1:0] high_rel;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl_q;
    logic             car_flag;
    logic             tick;
    logic             phase_high;

    assign ld_val = {ld_nib_hi, ld_nib_lo};

    carrier_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_val      (ld_val),
        .ld_low_stb  (ld_low_stb),
        .ld_high_stb (ld_high_stb),
        .ctrl_wr_stb (ctrl_wr_stb),
        .ctrl_wdata  (ctrl_wdata),
        .car_set_stb (car_set_stb),
        .car_clr_stb (car_clr_stb),
        .low_rel     (low_rel),
        .high_rel    (high_rel),
        .ctrl        (ctrl_q),
        .car_flag    (car_flag)
    );

    carrier_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (ctrl_wr_stb | ld_low_stb),
        .slow_sel (ctrl_q.src_slow),
        .tick     (tick)
    );

    carrier_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_stb   (ld_low_stb),
        .load_val   (ld_val),
        .tick       (tick),
        .run        (ctrl_q.run),
        .stretch_en (ctrl_q.stretch),
        .low_rel    (low_rel),
        .high_rel   (high_rel),
        .uf_clr     (uf_clr_stb),
        .count      (count),
        .phase_high (phase_high),
        .uf_flag    (uf_flag)
    );

    assign rd_nib_lo = count[NIB_W-1:0];
    assign rd_nib_hi = count[CNT_W-1:NIB_W];
    assign carr_out  = ctrl_q.run & car_flag & phase_high;

endmodule

// File: rtl/carrier_timer_chk.sv
module carrier_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_low_stb,
    input logic [CNT_W-1:0] ld_val,
    input logic             tick,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic             phase_high,
    input logic             uf_flag,
    input logic             uf_clr_stb,
    input logic             car_clr_stb,
    input logic             carr_out
);

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_low_stb |=> (count == $past(ld_val)));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_low_stb && run && tick && count != '0) |=> (count == $past(count) - 1'b1));

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && !ld_low_stb) |=> $stable(phase_high));

    assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !uf_clr_stb) |=> uf_flag);

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        car_clr_stb |=> !carr_out);

    assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_low_stb && !run) |=> $stable(count));

endmodule

bind carrier_timer carrier_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_low_stb  (ld_low_stb),
    .ld_val      (ld_val),
    .tick        (tick),
    .run         (ctrl_q.run),
    .count       (count),
    .phase_high  (phase_high),
    .uf_flag     (uf_flag),
    .uf_clr_stb  (uf_clr_stb),
    .car_clr_stb (car_clr_stb),
    .carr_out    (carr_out)
);

// File: tb/test_carrier_timer.sv
module test_carrier_timer;

    localparam int FAST = 2;
    localparam int SLOW = 8;
    localparam int NV   = 8;
    // {low reload, high reload, stretch, slow source}
    localparam logic [17:0] VECS [NV] = '{
        {8'd3,  8'd5,  1'b0, 1'b0},
        {8'd5,  8'd3,  1'b1, 1'b0},
        {8'd0,  8'd0,  1'b0, 1'b0},
        {8'd0,  8'd0,  1'b1, 1'b0},
        {8'd2,  8'd1,  1'b0, 1'b1},
        {8'd1,  8'd0,  1'b1, 1'b1},
        {8'd10, 8'd20, 1'b0, 1'b0},
        {8'd7,  8'd2,  1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ld_nib_lo = '0, ld_nib_hi = '0;
    logic       ld_low_stb = 1'b0, ld_high_stb = 1'b0, ctrl_wr_stb = 1'b0;
    logic [2:0] ctrl_wdata = '0;
    logic       car_set_stb = 1'b0, car_clr_stb = 1'b0, uf_clr_stb = 1'b0;
    logic       uf_flag;
    logic [3:0] rd_nib_lo, rd_nib_hi;
    logic       carr_out;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    carrier_timer #(.CNT_W(8), .FAST_DIV(FAST), .SLOW_DIV(SLOW)) i_carrier_timer (
        .clk(clk), .rst_n(rst_n), .ld_nib_lo(ld_nib_lo), .ld_nib_hi(ld_nib_hi),
        .ld_low_stb(ld_low_stb), .ld_high_stb(ld_high_stb),
        .ctrl_wr_stb(ctrl_wr_stb), .ctrl_wdata(ctrl_wdata),
        .car_set_stb(car_set_stb), .car_clr_stb(car_clr_stb),
        .uf_clr_stb(uf_clr_stb), .uf_flag(uf_flag),
        .rd_nib_lo(rd_nib_lo), .rd_nib_hi(rd_nib_hi), .carr_out(carr_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rd_count();
        return int'({rd_nib_hi, rd_nib_lo});
    endfunction

    task automatic load_low(input logic [7:0] v);
        @(negedge clk);
        {ld_nib_hi, ld_nib_lo} = v;
        ld_low_stb = 1'b1;
        @(negedge clk);
        ld_low_stb = 1'b0;
    endtask

    task automatic load_high(input logic [7:0] v);
        @(negedge clk);
        {ld_nib_hi, ld_nib_lo} = v;
        ld_high_stb = 1'b1;
        @(negedge clk);
        ld_high_stb = 1'b0;
    endtask

    task automatic write_ctrl(input logic [2:0] c);
        @(negedge clk);
        ctrl_wdata  = c;
        ctrl_wr_stb = 1'b1;
        @(negedge clk);
        ctrl_wr_stb = 1'b0;
    endtask

    task automatic pulse_car(input logic set);
        @(negedge clk);
        if (set) car_set_stb = 1'b1; else car_clr_stb = 1'b1;
        @(negedge clk);
        car_set_stb = 1'b0;
        car_clr_stb = 1'b0;
    endtask

    task automatic clear_uf();
        @(negedge clk);
        uf_clr_stb = 1'b1;
        @(negedge clk);
        uf_clr_stb = 1'b0;
    endtask

    // measure one high interval and the following low interval, in clocks
    task automatic measure(output int hi_len, output int lo_len);
        int guard;
        guard = 0;
        hi_len = 0;
        lo_len = 0;
        while (carr_out !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (carr_out !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        while (carr_out === 1'b1 && guard < 4000) begin hi_len++; @(negedge clk); guard++; end
        while (carr_out === 1'b0 && guard < 4000) begin lo_len++; @(negedge clk); guard++; end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog R5: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h, l;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count after reset", rd_count(), 255);
        chk("R1 uf after reset", int'(uf_flag), 0);
        chk("R1 output after reset", int'(carr_out), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 count holds while stopped", rd_count(), 255);

        pulse_car(1'b1);
        for (int i = 0; i < NV; i++) begin
            logic [7:0] lo_v, hi_v;
            logic       st, sl;
            int         div, exp_hi, exp_lo;
            {lo_v, hi_v, st, sl} = VECS[i];
            div    = sl ? SLOW : FAST;
            exp_hi = (int'(hi_v) + 1 + int'(st)) * div;
            exp_lo = (int'(lo_v) + 1) * div;
            write_ctrl(3'b000);
            load_high(hi_v);
            load_low(lo_v);
            write_ctrl({sl, st, 1'b1});
            for (int k = 0; k < 2; k++) begin
                measure(h, l);
                if (st) chk("R6 stretched high period", h, exp_hi);
                else if (sl) chk("R4 high period slow source", h, exp_hi);
                else chk("R5 high period", h, exp_hi);
                if (sl) chk("R4 low period slow source", l, exp_lo);
                else chk("R5 low period", l, exp_lo);
            end
        end

        // R2 load into counter and readback
        write_ctrl(3'b000);
        load_low(8'hA7);
        chk("R2 load readback", rd_count(), 8'hA7);

        // R10 high write leaves count alone
        load_high(8'h3C);
        chk("R10 count unchanged by high write", rd_count(), 8'hA7);

        // R3 decrement per fast tick
        load_low(8'h25);
        write_ctrl(3'b001);
        chk("R3 count right after enable", rd_count(), 8'h25);
        @(negedge clk);
        chk("R3 no tick yet", rd_count(), 8'h25);
        @(negedge clk);
        chk("R3 first decrement", rd_count(), 8'h24);
        repeat (2) @(negedge clk);
        chk("R3 second decrement", rd_count(), 8'h23);

        // R4 slow source timing
        write_ctrl(3'b000);
        load_low(8'h40);
        write_ctrl(3'b101);
        repeat (7) @(negedge clk);
        chk("R4 no slow tick before 8 clocks", rd_count(), 8'h40);
        @(negedge clk);
        chk("R4 slow tick at 8 clocks", rd_count(), 8'h3F);

        // R9 stop: count holds, output low
        write_ctrl(3'b000);
        h = rd_count();
        l = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (carr_out) l++;
        end
        chk("R9 count holds while stopped", rd_count(), h);
        chk("R9 output low while stopped", l, 0);

        // R7 sticky underflow flag
        clear_uf();
        chk("R7 flag cleared", int'(uf_flag), 0);
        load_high(8'h00);
        load_low(8'h00);
        write_ctrl(3'b001);
        repeat (10) @(negedge clk);
        chk("R7 flag set by underflow", int'(uf_flag), 1);
        write_ctrl(3'b000);
        repeat (6) @(negedge clk);
        chk("R7 flag sticky while stopped", int'(uf_flag), 1);
        clear_uf();
        chk("R7 flag cleared by strobe", int'(uf_flag), 0);

        // R8 gate flag clear keeps output low
        load_high(8'h01);
        load_low(8'h01);
        write_ctrl(3'b001);
        pulse_car(1'b0);
        l = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (carr_out) l++;
        end
        chk("R8 output low with gate clear", l, 0);
        // R8 clear wins over set
        @(negedge clk);
        car_set_stb = 1'b1;
        car_clr_stb = 1'b1;
        @(negedge clk);
        car_set_stb = 1'b0;
        car_clr_stb = 1'b0;
        l = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (carr_out) l++;
        end
        chk("R8 clear wins over set", l, 0);
        pulse_car(1'b1);
        measure(h, l);
        chk("R8 output resumes after set", h, 4);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule